// File: doc/BRIEF.md
# Multi-Mode Page Table Walker

This block turns a virtual address into a physical address by reading page-table entries from memory. The translation format is selected by the paging controls that come with each request. Paging can be off, so the address passes straight through. The other formats are the 32-bit two-level tables with 4-byte entries, the three-level extended format with 8-byte entries, and the four- or five-level long format. A walk can stop early on a large page at the directory level (2 MB or 4 MB) or at the third level from the bottom (1 GB).

A client hands over a request with a valid/ready handshake. The walker then issues entry reads one at a time on a simple read port, with never more than one read outstanding. It ends with a single-cycle `done` strobe that carries either the physical address and page size, or a fault flag. Permission checks, accessed/dirty updates and translation caching belong to neighbouring blocks.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high exactly when no walk is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Each request produces one `done` cycle. Out of reset `req_ready`=1, `done`=0 and `mem_rd_valid`=0.
- R2: With `pg_en`=0, `done` is high in the cycle right after acceptance. In that case `done_pa` is `req_va[PA_W-1:0] & a20_mask`, `done_size`=0 and `done_fault`=0, and no memory read is issued.
- R3: In two-level mode (`pg_en`=1, `pae_en`=0), the directory entry is a 4-byte read (`mem_rd_wide`=0) at `{cr3[31:12],12'h0} + va[31:22]*4`. The table entry is a 4-byte read at `{pde[31:12],12'h0} + va[21:12]*4`. The result is `{pte[31:12], va[11:0]}`.
- R4: In two-level mode, a directory entry with bit 7 set while `pse_en`=1 ends the walk with a 4 MB page. The result is `{pde[20:13], pde[31:22], va[21:0]}` and `done_size`=2. With `pse_en`=0, bit 7 has no effect and the table read still happens.
- R5: In extended mode (`pae_en`=1, `lma_en`=0), the first read is an 8-byte read (`mem_rd_wide`=1) at `(cr3 & ~0x1F) + va[31:30]*8`. Bit 7 of that entry is ignored. The next two reads are 8-byte reads indexed by `va[29:21]` and then `va[20:12]`. Each read uses the frame in bits [PA_W-1:12] of the previous entry.
- R6: In long mode (`pae_en`=1, `lma_en`=1), the walk faults without any memory read unless `va[63:47]` is all zeros or all ones. When `la57_en`=1 the bits checked are `va[63:56]` instead.
- R7: In long mode, the first read is at `{cr3[PA_W-1:12],12'h0}`. Its index is `va[56:48]*8` when `la57_en`=1 and `va[47:39]*8` otherwise. Later levels are indexed by `va[47:39]` (5-level only), then `va[38:30]`, `va[29:21]` and `va[20:12]`.
- R8: In extended or long mode, bit 7 set in the entry read with the `va[29:21]` index gives a 2 MB page. In long mode, bit 7 set in the entry read with the `va[38:30]` index gives a 1 GB page.
- R9: Every entry read address is ANDed with `a20_mask`. In two-level mode the final frame is ANDed with `a20_mask` as well.
- R10: A read entry with bit 0 clear ends the walk in the next cycle with `done_fault`=1. No further read is issued.
- R11: A successful result is the leaf frame with the bits below the page size cleared, ORed with the matching low bits of the virtual address. `done_size` encodes the page size as 0=4 KB, 1=2 MB, 2=4 MB, 3=1 GB.
- R12: Once `mem_rd_valid` rises, it stays high and `mem_rd_addr` stays stable until `mem_rd_ready`. No new read is issued until `mem_rsp_valid` has returned the previous entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 64 | Virtual address to translate |
| cr3 | input | PA_W | Root table pointer |
| pg_en | input | 1 | Paging enabled |
| pae_en | input | 1 | 8-byte entry formats selected |
| pse_en | input | 1 | 4 MB pages allowed in two-level mode |
| lma_en | input | 1 | Long mode active |
| la57_en | input | 1 | Five-level long mode |
| a20_mask | input | PA_W | Mask applied to entry addresses |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory takes the read |
| mem_rd_addr | output | PA_W | Entry byte address |
| mem_rd_wide | output | 1 | 1 = 8-byte read, 0 = 4-byte read |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry data, 4-byte reads zero-extended |
| done | output | 1 | One-cycle completion strobe |
| done_fault | output | 1 | Walk ended in a fault |
| done_pa | output | PA_W | Translated physical address |
| done_size | output | 2 | Page size code |

## Verification
The hardest case to reach is the combination of a back-pressured read port with a five-level walk that has to visit every level. The read address has to stay fixed across many stalled cycles, while each level's index comes from a different slice of a sign-extended address. The bench builds a sparse table image in which each level's entry sits exactly at the address that level's index selects. The responder then toggles its ready line every cycle during a long-mode walk, so each issue phase is stretched. Leaf termination at each level is reached with separate images whose size bit sits at the directory or third level. Faults come from non-canonical addresses and from absent slots in the same images.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
   localparam int VA_W      = 64;
   localparam int ENT_W     = 64;
   localparam int PRES_BIT  = 0;
   localparam int BIG_BIT   = 7;

   typedef enum logic [2:0] {
      PM_FLAT, PM_LEG32, PM_PAE, PM_LONG4, PM_LONG5
   } ptw_mode_e;

   typedef enum logic [1:0] {
      PS_4K = 2'd0, PS_2M = 2'd1, PS_4M = 2'd2, PS_1G = 2'd3
   } ptw_psize_e;

   typedef enum logic [1:0] {
      S_IDLE, S_ISSUE, S_WAIT
   } ptw_state_e;

   function automatic logic [2:0] top_level(input ptw_mode_e m);
      case (m)
         PM_LEG32: return 3'd1;
         PM_PAE:   return 3'd2;
         PM_LONG4: return 3'd3;
         PM_LONG5: return 3'd4;
         default:  return 3'd0;
      endcase
   endfunction
endpackage

// File: rtl/ptw_canon_chk.sv
`timescale 1ns/1ps
module ptw_canon_chk
   import ptw_pkg::*;
(
   input  logic [VA_W-1:0] va,
   input  logic            la57,
   output logic            canon_ok
);
   logic unused_low;
   assign unused_low = ^va[46:0];

   always_comb begin
      if (la57) canon_ok = (&va[63:56]) | ~(|va[63:56]);
      else      canon_ok = (&va[63:47]) | ~(|va[63:47]);
   end
endmodule

// File: rtl/ptw_entry_addr.sv
`timescale 1ns/1ps
module ptw_entry_addr
   import ptw_pkg::*;
#(
   parameter int PA_W = 52
) (
   input  ptw_mode_e        mode,
   input  logic [2:0]       level,
   input  logic [PA_W-1:0]  base,
   input  logic [VA_W-1:0]  va,
   input  logic [PA_W-1:0]  a20,
   output logic [PA_W-1:0]  addr,
   output logic             wide
);
   logic [8:0]      idx9;
   logic [9:0]      idx10;
   logic [PA_W-1:0] raw;
   logic            unused_bits;
   assign unused_bits = ^{va[63:57], va[11:0], base[4:0]};

   always_comb begin
      case (level)
         3'd0:    idx9 = va[20:12];
         3'd1:    idx9 = va[29:21];
         3'd2:    idx9 = va[38:30];
         3'd3:    idx9 = va[47:39];
         default: idx9 = va[56:48];
      endcase
      idx10 = level[0] ? va[31:22] : va[21:12];
   end

   always_comb begin
      case (mode)
         PM_LEG32: raw = PA_W'({base[31:12], 12'h000}) + PA_W'({idx10, 2'b00});
         PM_PAE: begin
            if (level == 3'd2)
               raw = {base[PA_W-1:5], 5'h00} + PA_W'({va[31:30], 3'b000});
            else
               raw = {base[PA_W-1:12], 12'h000} + PA_W'({idx9, 3'b000});
         end
         default:  raw = {base[PA_W-1:12], 12'h000} + PA_W'({idx9, 3'b000});
      endcase
      addr = raw & a20;
      wide = (mode != PM_LEG32);
   end
endmodule

// File: rtl/ptw_leaf_pa.sv
`timescale 1ns/1ps
module ptw_leaf_pa
   import ptw_pkg::*;
#(
   parameter int PA_W = 52
) (
   input  logic [ENT_W-1:0] entry,
   input  logic [VA_W-1:0]  va,
   input  ptw_psize_e       psize,
   input  logic             legacy,
   input  logic [PA_W-1:0]  a20,
   output logic [PA_W-1:0]  pa
);
   localparam logic [PA_W-1:0] OFF_4K = PA_W'(64'h0000_0FFF);
   localparam logic [PA_W-1:0] OFF_2M = PA_W'(64'h001F_FFFF);
   localparam logic [PA_W-1:0] OFF_4M = PA_W'(64'h003F_FFFF);
   localparam logic [PA_W-1:0] OFF_1G = PA_W'(64'h3FFF_FFFF);

   logic [PA_W-1:0] frame;
   logic [PA_W-1:0] off;
   logic            unused_bits;
   assign unused_bits = ^{entry[ENT_W-1:PA_W], va[VA_W-1:PA_W]};

   always_comb begin
      if (legacy) begin
         if (psize == PS_4M) frame = PA_W'({entry[20:13], entry[31:0]}) & a20;
         else                frame = PA_W'(entry[31:0]) & a20;
      end else begin
         frame = entry[PA_W-1:0];
      end
      case (psize)
         PS_2M:   off = OFF_2M;
         PS_4M:   off = OFF_4M;
         PS_1G:   off = OFF_1G;
         default: off = OFF_4K;
      endcase
      pa = (frame & ~off) | (va[PA_W-1:0] & off);
   end
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int PA_W        = 52,
   parameter bit FIVE_LVL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [63:0]       req_va,
   input  logic [PA_W-1:0]   cr3,
   input  logic              pg_en,
   input  logic              pae_en,
   input  logic              pse_en,
   input  logic              lma_en,
   input  logic              la57_en,
   input  logic [PA_W-1:0]   a20_mask,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [PA_W-1:0]   mem_rd_addr,
   output logic              mem_rd_wide,
   input  logic              mem_rsp_valid,
   input  logic [63:0]       mem_rsp_data,
   output logic              done,
   output logic              done_fault,
   output logic [PA_W-1:0]   done_pa,
   output logic [1:0]        done_size
);
   generate
      if (PA_W < 40 || PA_W > 52) begin : g_bad_pa_w
         $error("ptw_walker: PA_W must lie in 40..52");
      end
   endgenerate

   logic la57_eff;
   generate
      if (FIVE_LVL_EN) begin : g_five
         assign la57_eff = la57_en;
      end else begin : g_four
         logic unused_la57;
         assign unused_la57 = la57_en;
         assign la57_eff    = 1'b0;
      end
   endgenerate

   ptw_state_e      state_q;
   ptw_mode_e       mode_q, req_mode;
   ptw_psize_e      size_q, leaf_sz;
   logic [2:0]      level_q;
   logic [PA_W-1:0] base_q, a20_q, pa_q, leaf_pa;
   logic [VA_W-1:0] va_q;
   logic            pse_q, done_q, fault_q;
   logic            va_canon, is_leaf, ent_present, ent_big;

   always_comb begin
      if (!pg_en)       req_mode = PM_FLAT;
      else if (!pae_en) req_mode = PM_LEG32;
      else if (!lma_en) req_mode = PM_PAE;
      else if (la57_eff) req_mode = PM_LONG5;
      else              req_mode = PM_LONG4;
   end

   ptw_canon_chk u_canon (.va(req_va), .la57(la57_eff), .canon_ok(va_canon));

   ptw_entry_addr #(.PA_W(PA_W)) u_addr (
      .mode(mode_q), .level(level_q), .base(base_q), .va(va_q),
      .a20(a20_q), .addr(mem_rd_addr), .wide(mem_rd_wide));

   assign ent_present = mem_rsp_data[PRES_BIT];
   assign ent_big     = mem_rsp_data[BIG_BIT];

   always_comb begin
      is_leaf = 1'b0;
      leaf_sz = PS_4K;
      if (level_q == 3'd0) begin
         is_leaf = 1'b1;
      end else if (level_q == 3'd1 && ent_big) begin
         if (mode_q == PM_LEG32) begin
            is_leaf = pse_q;
            leaf_sz = PS_4M;
         end else begin
            is_leaf = 1'b1;
            leaf_sz = PS_2M;
         end
      end else if (level_q == 3'd2 && ent_big &&
                   (mode_q == PM_LONG4 || mode_q == PM_LONG5)) begin
         is_leaf = 1'b1;
         leaf_sz = PS_1G;
      end
   end

   ptw_leaf_pa #(.PA_W(PA_W)) u_leaf (
      .entry(mem_rsp_data), .va(va_q), .psize(leaf_sz),
      .legacy(mode_q == PM_LEG32), .a20(a20_q), .pa(leaf_pa));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         mode_q  <= PM_FLAT;
         level_q <= 3'd0;
         base_q  <= '0;
         a20_q   <= '0;
         va_q    <= '0;
         pse_q   <= 1'b0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         pa_q    <= '0;
         size_q  <= PS_4K;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            S_IDLE: if (req_valid) begin
               mode_q  <= req_mode;
               va_q    <= req_va;
               a20_q   <= a20_mask;
               pse_q   <= pse_en;
               level_q <= top_level(req_mode);
               base_q  <= cr3;
               if (req_mode == PM_FLAT) begin
                  done_q  <= 1'b1;
                  fault_q <= 1'b0;
                  pa_q    <= req_va[PA_W-1:0] & a20_mask;
                  size_q  <= PS_4K;
               end else if ((req_mode == PM_LONG4 || req_mode == PM_LONG5) && !va_canon) begin
                  done_q  <= 1'b1;
                  fault_q <= 1'b1;
                  pa_q    <= '0;
                  size_q  <= PS_4K;
               end else begin
                  state_q <= S_ISSUE;
               end
            end
            S_ISSUE: if (mem_rd_ready) state_q <= S_WAIT;
            S_WAIT: if (mem_rsp_valid) begin
               if (!ent_present) begin
                  done_q  <= 1'b1;
                  fault_q <= 1'b1;
                  pa_q    <= '0;
                  size_q  <= PS_4K;
                  state_q <= S_IDLE;
               end else if (is_leaf) begin
                  done_q  <= 1'b1;
                  fault_q <= 1'b0;
                  pa_q    <= leaf_pa;
                  size_q  <= leaf_sz;
                  state_q <= S_IDLE;
               end else begin
                  level_q <= level_q - 3'd1;
                  base_q  <= mem_rsp_data[PA_W-1:0];
                  state_q <= S_ISSUE;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign req_ready    = (state_q == S_IDLE);
   assign mem_rd_valid = (state_q == S_ISSUE);
   assign done         = done_q;
   assign done_fault   = fault_q;
   assign done_pa      = pa_q;
   assign done_size    = size_q;

   // R12
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

   // R1
   busy_noaccept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> !req_ready);

   // R2
   flat_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !pg_en) |=> (done && !done_fault && !mem_rd_valid));

   // R6
   canon_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && pg_en && pae_en && lma_en && !va_canon)
      |=> (done && done_fault && !mem_rd_valid));

   // R10
   absent_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WAIT && mem_rsp_valid && !mem_rsp_data[PRES_BIT])
      |=> (done && done_fault && req_ready));
endmodule

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
   localparam int PA_W = 52;
   localparam logic [PA_W-1:0] ONES = '1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready;
   logic [63:0] req_va = '0;
   logic [PA_W-1:0] cr3 = '0, a20_mask = '1;
   logic pg_en = 0, pae_en = 0, pse_en = 0, lma_en = 0, la57_en = 0;
   logic mem_rd_valid, mem_rd_ready, mem_rd_wide, mem_rsp_valid;
   logic [PA_W-1:0] mem_rd_addr, done_pa;
   logic [63:0] mem_rsp_data;
   logic done, done_fault;
   logic [1:0] done_size;

   always #4 clk = ~clk;

   ptw_walker #(.PA_W(PA_W)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .cr3(cr3), .pg_en(pg_en), .pae_en(pae_en), .pse_en(pse_en),
      .lma_en(lma_en), .la57_en(la57_en), .a20_mask(a20_mask),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
      .mem_rd_addr(mem_rd_addr), .mem_rd_wide(mem_rd_wide),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .done_fault(done_fault), .done_pa(done_pa), .done_size(done_size));

   int n_tests = 0, n_fail = 0;
   logic [63:0] mem_words [longint unsigned];
   int rd_count = 0;
   logic [PA_W-1:0] rd_log [8];
   logic rd_wide_log [8];
   logic stall_mode = 1'b0;
   logic [63:0] r_pa;
   logic r_fault;
   logic [1:0] r_size;
   int r_lat;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr64(input logic [63:0] a, input logic [63:0] v);
      mem_words[longint'(a >> 3)] = v;
   endtask

   task automatic wr32(input logic [63:0] a, input logic [31:0] v);
      logic [63:0] w;
      w = mem_words.exists(longint'(a >> 3)) ? mem_words[longint'(a >> 3)] : 64'h0;
      if (a[2]) w[63:32] = v; else w[31:0] = v;
      mem_words[longint'(a >> 3)] = w;
   endtask

   function automatic logic [63:0] rd_mem(input logic [PA_W-1:0] a, input logic wide);
      logic [63:0] w;
      w = mem_words.exists(longint'(a >> 3)) ? mem_words[longint'(a >> 3)] : 64'h0;
      if (wide) return w;
      return a[2] ? {32'h0, w[63:32]} : {32'h0, w[31:0]};
   endfunction

   // memory responder: fixed two-cycle read latency, optional ready toggling
   initial begin
      logic [PA_W-1:0] pend_addr;
      logic pend_wide, tog;
      int pend_cnt;
      pend_addr = '0; pend_wide = 0; pend_cnt = 0; tog = 0;
      mem_rd_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (pend_cnt != 0) begin
            pend_cnt--;
            if (pend_cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = rd_mem(pend_addr, pend_wide);
            end
         end
         tog = ~tog;
         mem_rd_ready = !stall_mode || tog;
         if (mem_rd_valid && mem_rd_ready && pend_cnt == 0) begin
            if (rd_count < 8) begin
               rd_log[rd_count] = mem_rd_addr;
               rd_wide_log[rd_count] = mem_rd_wide;
            end
            rd_count++;
            pend_addr = mem_rd_addr;
            pend_wide = mem_rd_wide;
            pend_cnt  = 2;
         end
      end
   end

   task automatic walk(input logic [63:0] va, input logic [PA_W-1:0] root,
                       input logic pg, input logic pae, input logic pse,
                       input logic lma, input logic l57, input logic [PA_W-1:0] a20);
      bit got;
      rd_count = 0;
      @(negedge clk);
      req_valid = 1; req_va = va; cr3 = root; a20_mask = a20;
      pg_en = pg; pae_en = pae; pse_en = pse; lma_en = lma; la57_en = l57;
      while (!req_ready) @(negedge clk);
      @(posedge clk); #1;
      req_valid = 0;
      got = 0; r_lat = 0;
      while (!got && r_lat < 300) begin
         @(negedge clk);
         r_lat++;
         if (done) begin
            got = 1; r_pa = 64'(done_pa); r_fault = done_fault; r_size = done_size;
         end
      end
      chk("R1 done strobe seen", 64'(got), 64'd1);
   endtask

   task automatic t_reset;
      chk("R1 reset ready", 64'(req_ready), 64'd1);
      chk("R1 reset done", 64'(done), 64'd0);
      chk("R1 reset rd_valid", 64'(mem_rd_valid), 64'd0);
   endtask

   task automatic t_flat;
      walk(64'h0000_1234_5678_9ABC, '0, 0, 0, 0, 0, 0, ONES & ~(52'h1 << 20));
      chk("R2 flat pa", r_pa, 64'h0000_1234_5668_9ABC);
      chk("R2 flat latency", 64'(r_lat), 64'd1);
      chk("R2 flat reads", 64'(rd_count), 64'd0);
      chk("R2 flat size", 64'(r_size), 64'd0);
      chk("R2 flat fault", 64'(r_fault), 64'd0);
   endtask

   task automatic t_leg4k;
      wr32(64'h3004, 32'h0000_7003);
      wr32(64'h7014, 32'h0012_3001);
      walk(64'h0040_5123, 52'h3ABC, 1, 0, 0, 0, 0, ONES);
      chk("R3 leg4k pa", r_pa, 64'h12_3123);
      chk("R3 leg4k reads", 64'(rd_count), 64'd2);
      chk("R3 leg4k dir addr", 64'(rd_log[0]), 64'h3004);
      chk("R3 leg4k tbl addr", 64'(rd_log[1]), 64'h7014);
      chk("R3 leg4k narrow read", 64'(rd_wide_log[0]), 64'd0);
      chk("R11 leg4k size", 64'(r_size), 64'd0);
   endtask

   task automatic t_leg4m;
      wr32(64'h3008, 32'h0C0B_4083);
      wr32(64'h0C0B_4004, 32'h0000_9001);
      walk(64'h0080_1234, 52'h3000, 1, 0, 1, 0, 0, ONES);
      chk("R4 4M pa", r_pa, 64'h5A_0C00_1234);
      chk("R4 4M size", 64'(r_size), 64'd2);
      chk("R4 4M reads", 64'(rd_count), 64'd1);
      walk(64'h0080_1234, 52'h3000, 1, 0, 0, 0, 0, ONES);
      chk("R4 big bit ignored pa", r_pa, 64'h9234);
      chk("R4 big bit ignored reads", 64'(rd_count), 64'd2);
      chk("R4 big bit ignored tbl addr", 64'(rd_log[1]), 64'h0C0B_4004);
   endtask

   task automatic t_pae;
      wr64(64'h2038, 64'h0000_0000_0004_0081);
      wr64(64'h4_0018, 64'h0000_0005_0000_1001);
      wr64(64'h5_0000_1018, 64'h8000_000A_BCDE_F001);
      walk(64'hC060_3456, 52'h2027, 1, 1, 0, 0, 0, ONES);
      chk("R5 pae pa", r_pa, 64'hA_BCDE_F456);
      chk("R5 pae reads", 64'(rd_count), 64'd3);
      chk("R5 pae ptr addr", 64'(rd_log[0]), 64'h2038);
      chk("R5 pae dir addr", 64'(rd_log[1]), 64'h4_0018);
      chk("R5 pae tbl addr", 64'(rd_log[2]), 64'h5_0000_1018);
      chk("R5 pae wide read", 64'(rd_wide_log[0]), 64'd1);
      wr64(64'h2020, 64'h0000_0000_0004_1001);
      wr64(64'h4_1018, 64'h0000_0001_2340_0081);
      walk(64'h0060_0ABC, 52'h2020, 1, 1, 0, 0, 0, ONES);
      chk("R8 pae 2M pa", r_pa, 64'h1_2340_0ABC);
      chk("R8 pae 2M size", 64'(r_size), 64'd1);
      chk("R8 pae 2M reads", 64'(rd_count), 64'd2);
      walk(64'h4000_0000, 52'h2020, 1, 1, 0, 0, 0, ONES);
      chk("R10 pae absent fault", 64'(r_fault), 64'd1);
      chk("R10 pae absent reads", 64'(rd_count), 64'd1);
   endtask

   task automatic t_long4;
      wr64(64'h1_0800, 64'h1_1003);
      wr64(64'h1_1008, 64'h1_2003);
      wr64(64'h1_2018, 64'h1_3003);
      wr64(64'h1_3008, 64'h0000_0ABC_DEF0_1063);
      stall_mode = 1'b1;
      walk(64'hFFFF_8000_4060_1234, 52'h1_0000, 1, 1, 0, 1, 0, ONES);
      stall_mode = 1'b0;
      chk("R12 stalled long pa", r_pa, 64'h0ABC_DEF0_1234);
      chk("R12 stalled long reads", 64'(rd_count), 64'd4);
      chk("R7 long4 top addr", 64'(rd_log[0]), 64'h1_0800);
      chk("R7 long4 last addr", 64'(rd_log[3]), 64'h1_3008);
      wr64(64'h1_0000, 64'h1_1003);
      wr64(64'h1_1018, 64'h0000_0008_0000_0083);
      walk(64'h0000_0000_C123_4567, 52'h1_0000, 1, 1, 0, 1, 0, ONES);
      chk("R8 1G pa", r_pa, 64'h8_0123_4567);
      chk("R11 1G size", 64'(r_size), 64'd3);
      chk("R8 1G reads", 64'(rd_count), 64'd2);
      wr64(64'h1_1000, 64'h1_4003);
      walk(64'h0000_0000_0020_0000, 52'h1_0000, 1, 1, 0, 1, 0, ONES);
      chk("R10 long absent fault", 64'(r_fault), 64'd1);
      chk("R10 long absent reads", 64'(rd_count), 64'd3);
      walk(64'h0000_8000_0000_0000, 52'h1_0000, 1, 1, 0, 1, 0, ONES);
      chk("R6 noncanon4 fault", 64'(r_fault), 64'd1);
      chk("R6 noncanon4 reads", 64'(rd_count), 64'd0);
      chk("R6 noncanon4 latency", 64'(r_lat), 64'd1);
   endtask

   task automatic t_long5;
      wr64(64'h2_07F8, 64'h2_1003);
      wr64(64'h2_1800, 64'h2_2003);
      wr64(64'h2_2000, 64'h2_3003);
      wr64(64'h2_3000, 64'h2_4003);
      wr64(64'h2_4028, 64'h7654_3001);
      walk(64'h00FF_8000_0000_5678, 52'h2_0000, 1, 1, 0, 1, 1, ONES);
      chk("R7 long5 pa", r_pa, 64'h7654_3678);
      chk("R7 long5 reads", 64'(rd_count), 64'd5);
      chk("R7 long5 top addr", 64'(rd_log[0]), 64'h2_07F8);
      chk("R6 long5 fault clear", 64'(r_fault), 64'd0);
      walk(64'h0100_0000_0000_0000, 52'h2_0000, 1, 1, 0, 1, 1, ONES);
      chk("R6 noncanon5 fault", 64'(r_fault), 64'd1);
      chk("R6 noncanon5 reads", 64'(rd_count), 64'd0);
   endtask

   task automatic t_a20;
      wr32(64'h3000, 32'h0010_8001);
      wr32(64'h8000, 32'h0030_5001);
      walk(64'h0000_0123, 52'h10_3000, 1, 0, 0, 0, 0, ONES & ~(52'h1 << 20));
      chk("R9 a20 dir addr", 64'(rd_log[0]), 64'h3000);
      chk("R9 a20 tbl addr", 64'(rd_log[1]), 64'h8000);
      chk("R9 a20 pa", r_pa, 64'h20_5123);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_flat();
      t_leg4k();
      t_leg4m();
      t_pae();
      t_long4();
      t_long5();
      t_a20();
      repeat (4) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule